// File: doc/BRIEF.md
# LCD Segment Row Serializer

This block produces the segment and common drive patterns for a two-row, 24-character dot-matrix panel. A scan sequencer walks the text store once for each dot row. It looks up the 5-dot row slice of each character code and shifts the slices one bit at a time into a 120-bit register. When the register is full, its contents move to the segment output latch, and the matching common line becomes active. Each common line covers one dot row of one text row, which gives 14 lines in all.

Codes 0 to 7 take their glyphs from a small writable pattern store. All other codes use a fixed table that is computed in logic. The host reaches both the text store and the pattern store through one request port. The single read port of each store is time-shared: even cycles serve the scan sequencer and odd cycles serve the host. Host traffic never stalls the refresh and never changes a segment output between latches.

Top module: `lcd_seg_serializer`

## Requirements
- R1: While rst_ni is low and after it rises, seg_o, com_o and frame_o are all zero and host_ack_o is low until the conditions of R2 are met.
- R2: host_ack_o is high only in odd cycles after reset (cycle 0 is the first rising edge after release), and only while host_req_i is high. A request held high is acknowledged within at most one extra cycle. The access completes at the rising edge that ends the acknowledge cycle, and host_rdata_o is valid during that acknowledge cycle.
- R3: With host_sel_i=0 the host addresses the text store, with locations 0..47 holding 8-bit codes. Addresses 48..63 read as zero, and writes to them are dropped.
- R4: With host_sel_i=1 the host addresses the pattern store at host_addr_i = {code[2:0] in bits 5:3, dot row in bits 2:0}. A write keeps host_wdata_i[4:0], and a read returns those bits zero-extended. Codes 0..7 take their row patterns from this store.
- R5: For codes 8..255 the row pattern of dot row r is bits 4:0 of (code + 9*r).
- R6: For common line l (text row t = l/7, dot row r = l%7), segment bit ch*5+k shows bit k of the row-r pattern of the code at text address t*24+ch. Bit 0 is the leftmost column.
- R7: Serial loading begins at the character with the highest address and ends at address t*24. Within each character it goes from the rightmost column to the leftmost. It takes one bit per even cycle. The latch updates one cycle after the last bit, so a line lasts 240 cycles and the first latch appears 240 cycles after reset release.
- R8: com_o has no bit set before the first latch and exactly one bit set afterwards. The first latch selects com_o[0], and each later latch moves the selection up by one bit, wrapping from bit 13 to bit 0.
- R9: frame_o is high for exactly the one cycle that follows a latch selecting com_o[0], and low otherwise.
- R10: seg_o changes only in a cycle where com_o also changes. Host writes made during a line leave the outputs unchanged until the next latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_req_i | input | 1 | Host access request, held until acknowledged |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_sel_i | input | 1 | 0 = text store, 1 = pattern store |
| host_addr_i | input | 6 | Host address |
| host_wdata_i | input | 8 | Host write data |
| host_ack_o | output | 1 | Access performed this cycle |
| host_rdata_o | output | 8 | Read data, valid with host_ack_o |
| seg_o | output | 120 | Latched segment pattern |
| com_o | output | 14 | One-hot active common line |
| frame_o | output | 1 | One-cycle pulse when common line 0 is selected |

## Verification
The wait-bound property assumes that a host request, once raised, is held with steady control, address and data until it is acknowledged. The bench's transfer task raises a request on a falling edge and drops it only after the rising edge that completes the access, so this assumption holds. The output properties make no assumption about host inputs, because the scan path reads the stores only in its own slots. For that reason the bench issues host writes in the middle of lines and checks that segment changes appear only at latch points.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;
  localparam int unsigned DEF_NUM_CHARS = 24;
  localparam int unsigned DEF_TEXT_ROWS = 2;
  localparam int unsigned DEF_CHAR_W    = 5;
  localparam int unsigned DEF_CHAR_H    = 7;
  localparam int unsigned DEF_CODE_W    = 8;
  localparam int unsigned DEF_CG_CODES  = 8;

  typedef enum logic {SEL_TEXT = 1'b0, SEL_GLYPH = 1'b1} host_sel_e;

  // fixed glyph table for codes outside the writable range
  function automatic logic [7:0] rom_row(input logic [7:0] code, input logic [7:0] row);
    return code + 8'(9) * row;
  endfunction
endpackage

// File: rtl/lcd_text_store.sv
module lcd_text_store #(
  parameter int unsigned DEPTH  = 48,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_slot_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [CODE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] disp_addr_i,
  output logic [CODE_W-1:0] rd_data_o
);
  localparam int unsigned SLOTS = 1 << ADDR_W;

  logic [CODE_W-1:0] mem_q [SLOTS];
  logic [ADDR_W-1:0] rd_addr;

  assign rd_addr   = host_slot_i ? host_addr_i : disp_addr_i;
  assign rd_data_o = (int'(rd_addr) < DEPTH) ? mem_q[rd_addr] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SLOTS; i++) mem_q[i] <= '0;
    end else if (wr_en_i && host_slot_i && (int'(host_addr_i) < DEPTH)) begin
      mem_q[host_addr_i] <= wdata_i;
    end
  end

  assert_wr_in_host_slot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> host_slot_i);
endmodule

// File: rtl/lcd_glyph_unit.sv
module lcd_glyph_unit
  import lcd_seg_pkg::*;
#(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned CHAR_W   = 5,
  parameter int unsigned ROW_W    = 3,
  parameter int unsigned CG_CODES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_slot_i,
  input  logic              wr_en_i,
  input  logic [$clog2(CG_CODES)+ROW_W-1:0] host_addr_i,
  input  logic [CHAR_W-1:0] wdata_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic [CHAR_W-1:0] host_rdata_o,
  output logic [CHAR_W-1:0] glyph_o
);
  localparam int unsigned IDX_W = $clog2(CG_CODES);
  localparam int unsigned CG_AW = IDX_W + ROW_W;
  localparam int unsigned SLOTS = 1 << CG_AW;

  logic [CHAR_W-1:0] cg_q [SLOTS];
  logic [CG_AW-1:0]  rd_addr;
  logic [CHAR_W-1:0] rd_data;
  logic [7:0]        rom_val;

  assign rd_addr      = host_slot_i ? host_addr_i : {code_i[IDX_W-1:0], row_i};
  assign rd_data      = cg_q[rd_addr];
  assign host_rdata_o = rd_data;
  assign rom_val      = rom_row(8'(code_i), 8'(row_i));
  assign glyph_o      = (int'(code_i) < CG_CODES) ? rd_data : rom_val[CHAR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SLOTS; i++) cg_q[i] <= '0;
    end else if (wr_en_i && host_slot_i) begin
      cg_q[host_addr_i] <= wdata_i;
    end
  end

  assert_cg_wr_in_host_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> host_slot_i);
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq #(
  parameter int unsigned NUM_CHARS = 24,
  parameter int unsigned TEXT_ROWS = 2,
  parameter int unsigned CHAR_W    = 5,
  parameter int unsigned CHAR_H    = 7,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned ROW_W     = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          disp_slot_i,
  input  logic [CHAR_W-1:0]             glyph_i,
  output logic [ADDR_W-1:0]             disp_addr_o,
  output logic [ROW_W-1:0]              row_o,
  output logic [NUM_CHARS*CHAR_W-1:0]   seg_o,
  output logic [TEXT_ROWS*CHAR_H-1:0]   com_o,
  output logic                          frame_o
);
  localparam int unsigned SEG_N = NUM_CHARS * CHAR_W;
  localparam int unsigned COM_N = TEXT_ROWS * CHAR_H;
  localparam int unsigned DEPTH = NUM_CHARS * TEXT_ROWS;
  localparam int unsigned CH_W  = $clog2(NUM_CHARS);
  localparam int unsigned COL_W = $clog2(CHAR_W);
  localparam int unsigned TR_W  = (TEXT_ROWS > 1) ? $clog2(TEXT_ROWS) : 1;
  localparam int unsigned COM_W = $clog2(COM_N);

  logic [CH_W-1:0]   char_q;
  logic [COL_W-1:0]  col_q;
  logic [TR_W-1:0]   trow_q;
  logic [ROW_W-1:0]  drow_q;
  logic [CHAR_W-1:0] pat_q;
  logic [SEG_N-1:0]  shift_q, seg_q;
  logic [COM_W-1:0]  com_idx_q, com_next;
  logic              com_on_q, latch_q, frame_q;
  logic              first_col, bit_in;

  assign disp_addr_o = ADDR_W'(int'(trow_q) * NUM_CHARS + int'(char_q));
  assign row_o       = drow_q;
  assign com_next    = COM_W'(int'(trow_q) * CHAR_H + int'(drow_q));
  assign first_col   = (col_q == COL_W'(CHAR_W - 1));
  // rightmost column comes straight from the lookup, the rest from the held pattern
  assign bit_in      = first_col ? glyph_i[CHAR_W-1] : pat_q[col_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      char_q    <= CH_W'(NUM_CHARS - 1);
      col_q     <= COL_W'(CHAR_W - 1);
      trow_q    <= '0;
      drow_q    <= '0;
      pat_q     <= '0;
      shift_q   <= '0;
      seg_q     <= '0;
      com_idx_q <= '0;
      com_on_q  <= 1'b0;
      latch_q   <= 1'b0;
      frame_q   <= 1'b0;
    end else if (latch_q) begin
      seg_q     <= shift_q;
      com_idx_q <= com_next;
      com_on_q  <= 1'b1;
      frame_q   <= (com_next == '0);
      latch_q   <= 1'b0;
      if (drow_q == ROW_W'(CHAR_H - 1)) begin
        drow_q <= '0;
        trow_q <= (trow_q == TR_W'(TEXT_ROWS - 1)) ? '0 : trow_q + 1'b1;
      end else begin
        drow_q <= drow_q + 1'b1;
      end
    end else begin
      frame_q <= 1'b0;
      if (disp_slot_i) begin
        shift_q <= {shift_q[SEG_N-2:0], bit_in};
        if (first_col) pat_q <= glyph_i;
        if (col_q == '0) begin
          col_q <= COL_W'(CHAR_W - 1);
          if (char_q == '0) begin
            char_q  <= CH_W'(NUM_CHARS - 1);
            latch_q <= 1'b1;
          end else begin
            char_q <= char_q - 1'b1;
          end
        end else begin
          col_q <= col_q - 1'b1;
        end
      end
    end
  end

  for (genvar k = 0; k < COM_N; k++) begin : g_com
    assign com_o[k] = com_on_q && (com_idx_q == COM_W'(k));
  end

  assign seg_o   = seg_q;
  assign frame_o = frame_q;

  logic [COM_N-1:0] com_rot;
  assign com_rot = {com_o[COM_N-2:0], com_o[COM_N-1]};

  assert_com_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(com_o));
  assert_com_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(com_on_q) && (com_o != $past(com_o))) |-> (com_o == $past(com_rot)));
  assert_frame_on_com0_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> com_o[0]);
  assert_no_flicker_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(seg_o) |-> !$stable(com_o));
  assert_fetch_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(disp_addr_o) < DEPTH);
endmodule

// File: rtl/lcd_seg_serializer.sv
module lcd_seg_serializer
  import lcd_seg_pkg::*;
#(
  parameter int unsigned NUM_CHARS = DEF_NUM_CHARS,
  parameter int unsigned TEXT_ROWS = DEF_TEXT_ROWS,
  parameter int unsigned CHAR_W    = DEF_CHAR_W,
  parameter int unsigned CHAR_H    = DEF_CHAR_H,
  parameter int unsigned CODE_W    = DEF_CODE_W,
  parameter int unsigned CG_CODES  = DEF_CG_CODES,
  localparam int unsigned SEG_N    = NUM_CHARS * CHAR_W,
  localparam int unsigned COM_N    = TEXT_ROWS * CHAR_H,
  localparam int unsigned DEPTH    = NUM_CHARS * TEXT_ROWS,
  localparam int unsigned ADDR_W   = $clog2(DEPTH),
  localparam int unsigned ROW_W    = $clog2(CHAR_H),
  localparam int unsigned CG_AW    = $clog2(CG_CODES) + ROW_W,
  localparam int unsigned HA_W     = (ADDR_W > CG_AW) ? ADDR_W : CG_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic              host_sel_i,
  input  logic [HA_W-1:0]   host_addr_i,
  input  logic [CODE_W-1:0] host_wdata_i,
  output logic              host_ack_o,
  output logic [CODE_W-1:0] host_rdata_o,
  output logic [SEG_N-1:0]  seg_o,
  output logic [COM_N-1:0]  com_o,
  output logic              frame_o
);
  logic              slot_q;
  logic              text_we, glyph_we;
  logic [ADDR_W-1:0] disp_addr;
  logic [ROW_W-1:0]  disp_row;
  logic [CODE_W-1:0] text_rd;
  logic [CHAR_W-1:0] glyph, cg_host_rd;

  // even cycles: refresh fetch, odd cycles: host
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= 1'b0;
    else         slot_q <= ~slot_q;
  end

  assign host_ack_o   = host_req_i & slot_q;
  assign text_we      = host_ack_o & host_we_i & (host_sel_i == SEL_TEXT);
  assign glyph_we     = host_ack_o & host_we_i & (host_sel_i == SEL_GLYPH);
  assign host_rdata_o = (host_sel_i == SEL_GLYPH) ? CODE_W'(cg_host_rd) : text_rd;

  lcd_text_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_text (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_slot_i (slot_q),
    .wr_en_i     (text_we),
    .host_addr_i (host_addr_i[ADDR_W-1:0]),
    .wdata_i     (host_wdata_i),
    .disp_addr_i (disp_addr),
    .rd_data_o   (text_rd)
  );

  lcd_glyph_unit #(.CODE_W(CODE_W), .CHAR_W(CHAR_W), .ROW_W(ROW_W), .CG_CODES(CG_CODES)) u_glyph (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_slot_i  (slot_q),
    .wr_en_i      (glyph_we),
    .host_addr_i  (host_addr_i[CG_AW-1:0]),
    .wdata_i      (host_wdata_i[CHAR_W-1:0]),
    .code_i       (text_rd),
    .row_i        (disp_row),
    .host_rdata_o (cg_host_rd),
    .glyph_o      (glyph)
  );

  lcd_scan_seq #(
    .NUM_CHARS(NUM_CHARS), .TEXT_ROWS(TEXT_ROWS), .CHAR_W(CHAR_W),
    .CHAR_H(CHAR_H), .ADDR_W(ADDR_W), .ROW_W(ROW_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .disp_slot_i (~slot_q),
    .glyph_i     (glyph),
    .disp_addr_o (disp_addr),
    .row_o       (disp_row),
    .seg_o       (seg_o),
    .com_o       (com_o),
    .frame_o     (frame_o)
  );

  assert_host_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && !host_ack_o) |=> (!host_req_i || host_ack_o));
  assert_ack_alternates_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ack_o |=> !host_ack_o);
endmodule

// File: tb/lcd_seg_serializer_bench.sv
module lcd_seg_serializer_bench;
  localparam int CLK_P = 10;
  localparam int NCH = 24, CW = 5, CH = 7, NCOM = 14, DEPTH = 48, SEGN = 120;
  localparam int LINE_CYC = 240;

  logic         clk = 1'b0, rst_ni = 1'b0;
  logic         host_req = 1'b0, host_we = 1'b0, host_sel = 1'b0;
  logic [5:0]   host_addr = '0;
  logic [7:0]   host_wdata = '0;
  logic         host_ack, frame;
  logic [7:0]   host_rdata;
  logic [119:0] seg;
  logic [13:0]  com;

  int errors = 0, checks = 0, viol = 0;
  logic [7:0]   text_m [64];
  logic [4:0]   cg_m [64];
  logic [119:0] seg_prev = '0;
  logic [13:0]  com_prev = '0;

  always #(CLK_P/2) clk = ~clk;

  lcd_seg_serializer u_lcd_seg_serializer (
    .clk_i(clk), .rst_ni(rst_ni), .host_req_i(host_req), .host_we_i(host_we),
    .host_sel_i(host_sel), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_ack_o(host_ack), .host_rdata_o(host_rdata),
    .seg_o(seg), .com_o(com), .frame_o(frame)
  );

  // {sel, addr, wdata, expected read-back}
  localparam logic [22:0] VEC [6] = '{
    {1'b0, 6'd0,    8'h41, 8'h41},
    {1'b0, 6'd47,   8'h7e, 8'h7e},
    {1'b0, 6'd50,   8'h33, 8'h00},
    {1'b1, 6'h11,   8'hff, 8'h1f},
    {1'b1, 6'h3f,   8'h15, 8'h15},
    {1'b0, 6'd23,   8'h05, 8'h05}
  };

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] glyph_of(input logic [7:0] code, input int row);
    logic [7:0] v;
    if (code < 8) return cg_m[{code[2:0], 3'(row)}];
    v = code + 8'(9 * row);
    return v[4:0];
  endfunction

  function automatic logic [119:0] exp_line(input int l);
    logic [119:0] s = '0;
    logic [4:0] g;
    for (int ch = 0; ch < NCH; ch++) begin
      g = glyph_of(text_m[(l / CH) * NCH + ch], l % CH);
      for (int k = 0; k < CW; k++) s[ch*CW + k] = g[k];
    end
    return s;
  endfunction

  task automatic xfer(input logic sel, input logic we, input logic [5:0] addr,
                      input logic [7:0] wd, output logic [7:0] rd, output int waits);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_sel = sel; host_addr = addr; host_wdata = wd;
    waits = 0;
    #1;
    while (!host_ack) begin @(negedge clk); #1; waits++; end
    rd = host_rdata;
    @(posedge clk); #1;
    host_req = 1'b0; host_we = 1'b0;
    if (we) begin
      if (!sel && addr < DEPTH) text_m[addr] = wd;
      if (sel) cg_m[addr] = wd[4:0];
    end
  endtask

  task automatic wait_frame();
    @(negedge clk);
    while (!frame) @(negedge clk);
  endtask

  task automatic check_frame();
    int n;
    logic [13:0] pc;
    wait_frame();
    check(com == 14'd1, "R8", 128'(com), 128'd1);
    check(seg == exp_line(0), "R6", 128'(seg), 128'(exp_line(0)));
    for (int l = 1; l < NCOM; l++) begin
      n = 0; pc = com;
      do begin @(negedge clk); n++; end while (com == pc && n < 1000);
      check(n == LINE_CYC, "R7", 128'(n), 128'(LINE_CYC));
      check(com == 14'(1 << l), "R8", 128'(com), 128'(1 << l));
      check(seg == exp_line(l), "R6", 128'(seg), 128'(exp_line(l)));
      check(frame == 1'b0, "R9", 128'(frame), 128'd0);
    end
  endtask

  // R10 monitor: segment changes only together with a common change
  always @(negedge clk) begin
    if (rst_ni && seg != seg_prev && com == com_prev) viol++;
    seg_prev <= seg;
    com_prev <= com;
  end

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int w, n;
    for (int i = 0; i < 64; i++) begin text_m[i] = '0; cg_m[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(seg == '0 && com == '0 && frame == 1'b0, "R1", 128'({seg, com, frame}), 128'd0);
    check(host_ack == 1'b0, "R1", 128'(host_ack), 128'd0);
    rst_ni = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (com == '0 && n < 1000);
    check(n == LINE_CYC, "R7", 128'(n), 128'(LINE_CYC));
    check(com == 14'd1 && frame, "R9", 128'({com, frame}), 128'({14'd1, 1'b1}));
    check(seg == '0, "R1", 128'(seg), 128'd0);

    // vector table: write then read back (R2, R3, R4)
    foreach (VEC[i]) begin
      xfer(VEC[i][22], 1'b1, VEC[i][21:16], VEC[i][15:8], rd, w);
      check(w <= 1, "R2", 128'(w), 128'd1);
      xfer(VEC[i][22], 1'b0, VEC[i][21:16], 8'h00, rd, w);
      check(w <= 1, "R2", 128'(w), 128'd1);
      check(rd == VEC[i][7:0], VEC[i][22] ? "R4" : "R3", 128'(rd), 128'(VEC[i][7:0]));
    end

    // fill pattern store (R4) and text store with mixed codes (R5)
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < CH; r++)
        xfer(1'b1, 1'b1, 6'({3'(c), 3'(r)}), 8'((c * 7 + r * 3 + 1) & 31), rd, w);
    for (int a = 0; a < DEPTH; a++)
      xfer(1'b0, 1'b1, 6'(a), (a % 6 == 0) ? 8'(a % 8) : 8'((a * 37 + 11) & 255), rd, w);
    wait_frame();
    check_frame();

    // mid-line host writes must not disturb outputs (R10)
    viol = 0;
    repeat (30) @(negedge clk);
    for (int a = 0; a < 12; a++) xfer(1'b0, 1'b1, 6'(a * 4), 8'(200 - a * 9), rd, w);
    xfer(1'b1, 1'b1, 6'h0a, 8'h0e, rd, w);
    check(viol == 0, "R10", 128'(viol), 128'd0);
    wait_frame();
    check_frame();
    check(viol == 0, "R10", 128'(viol), 128'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule